// File: doc/BRIEF.md
# Link Protection State Supervisor

This block supervises content protection on a single display link. It holds one of three protection states: off (not wanted), wanted (protection requested but not currently in force), and on (authenticated and encrypting). A user turn-on request starts authentication through an external sequencer, using a start/done/pass handshake. Once the state is not off, a period timer runs. Each time it expires, the block looks at the encryption-active status and the link-integrity result, then either confirms the state or starts recovery.

Recovery is two steps. The first is a quiesce step: the block pulses a configuration clear, waits a bounded time for the whole status word to read zero, then pulses signalling off. The second step re-runs authentication. The policy favours re-applying protection later. Losing encryption, failing recovery or detaching the connector all demote the on state to wanted, not to off. A user turn-off request is the only way to reach off.

Requests that arrive while a quiesce or authentication is running are held. They are serviced in this priority order once the block is idle again: turn-off first, then detach, then turn-on. A periodic check runs only when nothing is pending. The control pins are plain levels and single-cycle pulses. No data stream passes through the block, so it has no back-pressure.

Top module: `link_guard_monitor`

## Requirements
- R1: After reset the protection state output is 0 (off), and the clear, signalling-off, start and error outputs are low. State encoding: 0 off, 1 wanted, 2 on.
- R2: While the state is off, no periodic check takes place. The error output stays low and no authentication start is issued, even with encryption inactive.
- R3: A turn-on request while the state is not on sets the state to wanted and pulses `auth_start_o`. When `auth_done_i` arrives, the state becomes on if `auth_pass_i` is high, and wanted otherwise.
- R4: If encryption is inactive at a check, the state becomes wanted and `enc_err_o` pulses for one cycle. No clear and no authentication start are issued.
- R5: Checks recur exactly every PERIOD clock cycles while the block is idle with the state not off. The timer restarts after every check and after every operation.
- R6: If encryption is active and the integrity result is good at a check, the state becomes on. This includes a check made while the state is wanted.
- R7: If encryption is active and the integrity result is bad at a check, the block pulses `cfg_clr_o`, then `sig_off_o`, then `auth_start_o`, in that order. The final state follows the pass flag, and a failed authentication leaves the state at wanted.
- R8: During quiesce, `sig_off_o` pulses only after `stat_zero_i` has been seen high. If `stat_zero_i` is not seen within QUIESCE_TMO cycles of the clear pulse, the state becomes wanted and no signalling-off or start follows.
- R9: A turn-off request sets the state to off and runs a quiesce only if the state was not already off. Afterwards no further checks run. The state leaves off only by going to wanted.
- R10: A detach while the state is on demotes it to wanted. A detach in any other state has no effect.
- R11: Turn-on, turn-off and detach requests that arrive during a quiesce or authentication are held and serviced after the operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_on_i | input | 1 | Pulse: user asks for protection |
| usr_off_i | input | 1 | Pulse: user asks to turn protection off |
| detach_i | input | 1 | Pulse: connector detached |
| enc_active_i | input | 1 | Encryption-active status level |
| link_ok_i | input | 1 | Link-integrity result level |
| cfg_clr_o | output | 1 | Pulse: clear protection configuration |
| stat_zero_i | input | 1 | Whole protection status word reads zero |
| sig_off_o | output | 1 | Pulse: turn protection signalling off |
| auth_start_o | output | 1 | Pulse: start authentication sequencer |
| auth_done_i | input | 1 | Pulse: authentication finished |
| auth_pass_i | input | 1 | Authentication result, valid with done |
| prot_state_o | output | 2 | Protection state (0 off, 1 wanted, 2 on) |
| enc_err_o | output | 1 | Pulse: encryption found inactive at a check |

## Verification
The check path is exercised with all three input combinations at check time. Encryption off must give a demotion plus an error and no recovery. Encryption on with good integrity must promote or confirm the on state. Encryption on with bad integrity must give the full clear, signalling-off, start sequence. Recovery is swept over several status-clear latencies and over authentication latencies. This separates correct event ordering from off-by-one waits, and a never-clearing status measures the exact timeout length. Requests injected mid-operation distinguish held requests from dropped ones. Detach and turn-off applied in each state show where they act and where they do nothing.

// File: rtl/link_guard_pkg.sv
package link_guard_pkg;
  typedef enum logic [1:0] {
    PROT_OFF  = 2'd0,
    PROT_WANT = 2'd1,
    PROT_ON   = 2'd2
  } prot_e;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_QUIESCE = 2'd1,
    OP_AUTH    = 2'd2
  } op_e;
endpackage

// File: rtl/link_guard_timer.sv
module link_guard_timer #(
  parameter int unsigned PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i || tick_o) cnt_q <= '0;
    else if (run_i)                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/link_guard_quiesce.sv
module link_guard_quiesce #(
  parameter int unsigned TMO = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic stat_zero_i,
  output logic cfg_clr_o,
  output logic sig_off_o,
  output logic done_o,
  output logic ok_o
);
  localparam int unsigned TW = (TMO > 1) ? $clog2(TMO) : 1;
  localparam logic [TW-1:0] LAST = TW'(TMO - 1);

  logic          busy_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      cfg_clr_o <= 1'b0;
      sig_off_o <= 1'b0;
      done_o    <= 1'b0;
      ok_o      <= 1'b0;
    end else begin
      cfg_clr_o <= go_i;
      sig_off_o <= 1'b0;
      done_o    <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (stat_zero_i) begin
          busy_q    <= 1'b0;
          done_o    <= 1'b1;
          ok_o      <= 1'b1;
          sig_off_o <= 1'b1;
        end else if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          ok_o   <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/link_guard_monitor.sv
module link_guard_monitor
  import link_guard_pkg::*;
#(
  parameter int unsigned PERIOD      = 100000,
  parameter int unsigned QUIESCE_TMO = 5000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       usr_on_i,
  input  logic       usr_off_i,
  input  logic       detach_i,
  input  logic       enc_active_i,
  input  logic       link_ok_i,
  output logic       cfg_clr_o,
  input  logic       stat_zero_i,
  output logic       sig_off_o,
  output logic       auth_start_o,
  input  logic       auth_done_i,
  input  logic       auth_pass_i,
  output logic [1:0] prot_state_o,
  output logic       enc_err_o
);
  prot_e state_q;
  op_e   op_q;
  logic  recover_q;
  logic  pend_on_q, pend_off_q, pend_det_q;
  logic  start_q, err_q;

  logic req_on, req_off, req_det, idle;
  logic svc_on, svc_off, svc_det;
  logic run, tick, q_go, q_done, q_ok;

  always_comb begin
    req_on  = usr_on_i  | pend_on_q;
    req_off = usr_off_i | pend_off_q;
    req_det = detach_i  | pend_det_q;
    idle    = (op_q == OP_IDLE);
    svc_off = idle && req_off;
    svc_det = idle && !req_off && req_det;
    svc_on  = idle && !req_off && !req_det && req_on;
    run     = idle && !req_off && !req_det && !req_on && (state_q != PROT_OFF);
    q_go    = (svc_off && state_q != PROT_OFF) ||
              (tick && enc_active_i && !link_ok_i);
  end

  link_guard_timer #(.PERIOD(PERIOD)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!idle || state_q == PROT_OFF),
    .run_i  (run),
    .tick_o (tick)
  );

  link_guard_quiesce #(.TMO(QUIESCE_TMO)) u_quiesce (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (q_go),
    .stat_zero_i (stat_zero_i),
    .cfg_clr_o   (cfg_clr_o),
    .sig_off_o   (sig_off_o),
    .done_o      (q_done),
    .ok_o        (q_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= PROT_OFF;
      op_q       <= OP_IDLE;
      recover_q  <= 1'b0;
      pend_on_q  <= 1'b0;
      pend_off_q <= 1'b0;
      pend_det_q <= 1'b0;
      start_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      start_q    <= 1'b0;
      err_q      <= 1'b0;
      pend_off_q <= req_off && !svc_off;
      pend_det_q <= req_det && !svc_det;
      pend_on_q  <= req_on  && !svc_on;
      unique case (op_q)
        OP_IDLE: begin
          if (svc_off) begin
            if (state_q != PROT_OFF) begin
              state_q   <= PROT_OFF;
              op_q      <= OP_QUIESCE;
              recover_q <= 1'b0;
            end
          end else if (svc_det) begin
            if (state_q == PROT_ON) state_q <= PROT_WANT;
          end else if (svc_on) begin
            if (state_q != PROT_ON) begin
              state_q <= PROT_WANT;
              start_q <= 1'b1;
              op_q    <= OP_AUTH;
            end
          end else if (tick) begin
            if (!enc_active_i) begin
              state_q <= PROT_WANT;
              err_q   <= 1'b1;
            end else if (link_ok_i) begin
              state_q <= PROT_ON;
            end else begin
              op_q      <= OP_QUIESCE;
              recover_q <= 1'b1;
            end
          end
        end
        OP_QUIESCE: begin
          if (q_done) begin
            if (recover_q && q_ok) begin
              start_q <= 1'b1;
              op_q    <= OP_AUTH;
            end else begin
              if (recover_q) state_q <= PROT_WANT;
              op_q <= OP_IDLE;
            end
          end
        end
        OP_AUTH: begin
          if (auth_done_i) begin
            state_q <= auth_pass_i ? PROT_ON : PROT_WANT;
            op_q    <= OP_IDLE;
          end
        end
        default: op_q <= OP_IDLE;
      endcase
    end
  end

  assign auth_start_o = start_q;
  assign enc_err_o    = err_q;
  assign prot_state_o = state_q;
endmodule

// File: rtl/link_guard_checker.sv
module link_guard_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enc_active_i,
  input logic       link_ok_i,
  input logic       stat_zero_i,
  input logic       auth_done_i,
  input logic       auth_pass_i,
  input logic       cfg_clr_o,
  input logic       sig_off_o,
  input logic       auth_start_o,
  input logic [1:0] prot_state_o,
  input logic       enc_err_o
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_state_o == 2'd0) |-> (!auth_start_o && !enc_err_o)); // R2

  AST_ERR_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    enc_err_o |-> (prot_state_o == 2'd1)); // R4

  AST_ON_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_state_o == 2'd2 && $past(prot_state_o) != 2'd2) |->
      ($past(auth_done_i && auth_pass_i) || $past(enc_active_i && link_ok_i))); // R6

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_clr_o, sig_off_o, auth_start_o})); // R7

  AST_SIGOFF_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sig_off_o |-> $past(stat_zero_i)); // R8

  AST_OFF_EXIT_WANT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(prot_state_o) == 2'd0 && prot_state_o != 2'd0) |-> (prot_state_o == 2'd1)); // R9
endmodule

bind link_guard_monitor link_guard_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enc_active_i (enc_active_i),
  .link_ok_i    (link_ok_i),
  .stat_zero_i  (stat_zero_i),
  .auth_done_i  (auth_done_i),
  .auth_pass_i  (auth_pass_i),
  .cfg_clr_o    (cfg_clr_o),
  .sig_off_o    (sig_off_o),
  .auth_start_o (auth_start_o),
  .prot_state_o (prot_state_o),
  .enc_err_o    (enc_err_o)
);

// File: tb/link_guard_monitor_bench.sv
module link_guard_monitor_bench;
  localparam int P   = 8;
  localparam int TMO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usr_on_i = 0, usr_off_i = 0, detach_i = 0;
  logic enc_active_i = 1, link_ok_i = 1, stat_zero_i = 0;
  logic auth_done_i = 0, auth_pass_i = 0;
  logic cfg_clr_o, sig_off_o, auth_start_o, enc_err_o;
  logic [1:0] prot_state_o;

  always #4 clk = ~clk;

  link_guard_monitor #(.PERIOD(P), .QUIESCE_TMO(TMO)) u_link_guard_monitor (
    .clk(clk), .rst_n(rst_n), .usr_on_i(usr_on_i), .usr_off_i(usr_off_i),
    .detach_i(detach_i), .enc_active_i(enc_active_i), .link_ok_i(link_ok_i),
    .cfg_clr_o(cfg_clr_o), .stat_zero_i(stat_zero_i), .sig_off_o(sig_off_o),
    .auth_start_o(auth_start_o), .auth_done_i(auth_done_i), .auth_pass_i(auth_pass_i),
    .prot_state_o(prot_state_o), .enc_err_o(enc_err_o));

  int checks = 0, fails = 0;
  int cyc_n = 0;
  int n_start = 0, n_clr = 0, n_off = 0, n_err = 0;
  int t_clr = 0, t_off = 0, t_start = 0, t_err = 0;
  int auth_lat = 2, zero_lat = 1;
  logic pass_cfg = 1'b1;
  int a_cnt = 0, z_cnt = 0;
  logic a_busy = 0, z_busy = 0;

  // Responders and pulse counters, all away from the active edge.
  always @(negedge clk) begin
    cyc_n++;
    auth_done_i = 1'b0;
    if (auth_start_o) begin n_start++; t_start = cyc_n; a_busy = 1; a_cnt = auth_lat; end
    else if (a_busy) begin
      if (a_cnt <= 1) begin auth_done_i = 1'b1; auth_pass_i = pass_cfg; a_busy = 0; end
      else a_cnt--;
    end
    if (cfg_clr_o) begin
      n_clr++; t_clr = cyc_n; stat_zero_i = 1'b0;
      if (zero_lat == 0) begin stat_zero_i = 1'b1; z_busy = 0; end
      else if (zero_lat > 0) begin z_busy = 1; z_cnt = zero_lat; end
      else z_busy = 0;
    end else if (z_busy) begin
      if (z_cnt <= 1) begin stat_zero_i = 1'b1; z_busy = 0; end else z_cnt--;
    end
    if (sig_off_o) begin n_off++; t_off = cyc_n; end
    if (enc_err_o) begin n_err++; t_err = cyc_n; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_on();  usr_on_i  = 1; @(negedge clk); usr_on_i  = 0; endtask
  task automatic pulse_off(); usr_off_i = 1; @(negedge clk); usr_off_i = 0; endtask
  task automatic pulse_det(); detach_i  = 1; @(negedge clk); detach_i  = 0; endtask

  task automatic wait_state(input int v, input int lim);
    for (int i = 0; i < lim; i++) begin
      if (prot_state_o == v) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int s0, c0, o0, e0, k;
    cyc(3);
    // R1 reset values
    chk(prot_state_o == 0 && !cfg_clr_o && !sig_off_o && !auth_start_o && !enc_err_o,
        "R1", prot_state_o, 0);
    rst_n = 1;

    // R2 off state is quiet even with encryption inactive
    enc_active_i = 0;
    cyc(4 * P);
    chk(n_err == 0 && n_start == 0 && prot_state_o == 0, "R2", n_err + n_start, 0);
    enc_active_i = 1;

    // R3 sweep of authentication latencies, R9 turn-off back to off
    for (int lat = 1; lat <= 4; lat++) begin
      auth_lat = lat; pass_cfg = 1; zero_lat = 1;
      s0 = n_start; c0 = n_clr;
      pulse_on();
      chk(prot_state_o == 1, "R3 want after on", prot_state_o, 1);
      wait_state(2, 20);
      chk(prot_state_o == 2 && n_start == s0 + 1, "R3 pass gives on", prot_state_o, 2);
      pulse_off();
      cyc(TMO + 4);
      chk(prot_state_o == 0 && n_clr == c0 + 1, "R9 off quiesces", n_clr - c0, 1);
      e0 = n_err; enc_active_i = 0;
      cyc(3 * P);
      chk(n_err == e0 && n_clr == c0 + 1, "R9 no checks after off", n_err - e0, 0);
      enc_active_i = 1;
    end

    // R9 off while already off does nothing
    c0 = n_clr;
    pulse_off(); cyc(TMO + 4);
    chk(n_clr == c0 && prot_state_o == 0, "R9 off when off", n_clr - c0, 0);

    // R10 detach while off has no effect
    pulse_det(); cyc(3);
    chk(prot_state_o == 0, "R10 detach when off", prot_state_o, 0);

    // R3 failing authentication leaves wanted
    pass_cfg = 0; auth_lat = 2; link_ok_i = 1;
    pulse_on(); cyc(4);
    chk(prot_state_o == 1, "R3 fail gives want", prot_state_o, 1);

    // R6 check with good integrity promotes wanted to on
    pass_cfg = 1;
    wait_state(2, P + 3);
    chk(prot_state_o == 2, "R6 integrity promotes", prot_state_o, 2);

    // R4 encryption loss demotes without recovery
    s0 = n_start; c0 = n_clr; e0 = n_err;
    enc_active_i = 0;
    for (int i = 0; i < P + 3; i++) begin if (n_err != e0) break; @(negedge clk); end
    chk(n_err == e0 + 1 && prot_state_o == 1, "R4 demote and flag", n_err - e0, 1);
    chk(n_start == s0 && n_clr == c0, "R4 no recovery", n_start - s0 + n_clr - c0, 0);

    // R5 check period measured between error pulses
    k = t_err;
    for (int i = 0; i < P + 3; i++) begin if (t_err != k) break; @(negedge clk); end
    chk(t_err - k == P, "R5 period", t_err - k, P);
    k = t_err;
    for (int i = 0; i < P + 3; i++) begin if (t_err != k) break; @(negedge clk); end
    chk(t_err - k == P, "R5 period repeat", t_err - k, P);
    enc_active_i = 1;
    wait_state(2, P + 3);
    chk(prot_state_o == 2, "R6 restore on", prot_state_o, 2);

    // R7 recovery sweep over status-clear latencies
    for (int zl = 0; zl <= 3; zl++) begin
      zero_lat = zl; pass_cfg = 1; auth_lat = 2;
      s0 = n_start; c0 = n_clr; o0 = n_off;
      link_ok_i = 0;
      for (int i = 0; i < P + 20; i++) begin if (n_start != s0) break; @(negedge clk); end
      link_ok_i = 1;
      cyc(auth_lat + 3);
      chk(n_clr == c0 + 1 && n_off == o0 + 1 && n_start == s0 + 1, "R7 counts",
          n_clr - c0 + n_off - o0 + n_start - s0, 3);
      chk(t_clr < t_off && t_off < t_start, "R7 order", t_off - t_clr, 1);
      chk(prot_state_o == 2, "R7 reauth pass", prot_state_o, 2);
    end

    // R7 recovery with failing authentication
    pass_cfg = 0; zero_lat = 1; s0 = n_start;
    link_ok_i = 0;
    for (int i = 0; i < P + 20; i++) begin if (n_start != s0) break; @(negedge clk); end
    link_ok_i = 1; cyc(auth_lat + 2);
    chk(prot_state_o == 1, "R7 reauth fail gives want", prot_state_o, 1);
    pass_cfg = 1;
    wait_state(2, P + 3);

    // R8 quiesce timeout
    zero_lat = -1; s0 = n_start; o0 = n_off; c0 = n_clr;
    link_ok_i = 0;
    for (int i = 0; i < P + 3; i++) begin if (n_clr != c0) break; @(negedge clk); end
    k = 0;
    for (int i = 0; i < TMO + 10; i++) begin
      if (prot_state_o == 1) break;
      @(negedge clk); k++;
    end
    link_ok_i = 1;
    chk(k == TMO, "R8 timeout length", k, TMO);
    chk(n_off == o0 && n_start == s0, "R8 no signalling off", n_off - o0 + n_start - s0, 0);
    zero_lat = 1;
    wait_state(2, P + 3);

    // R10 detach while on demotes
    pulse_det(); cyc(1);
    chk(prot_state_o == 1, "R10 detach demotes", prot_state_o, 1);
    wait_state(2, P + 3);

    // R11 turn-off held during authentication
    pulse_off(); cyc(TMO + 4);
    auth_lat = 5; c0 = n_clr;
    pulse_on(); cyc(1);
    pulse_off();
    cyc(20);
    chk(prot_state_o == 0 && n_clr == c0 + 1, "R11 held off", n_clr - c0, 1);

    // R11 detach held during recovery quiesce
    auth_lat = 2; pulse_on(); wait_state(2, 10);
    zero_lat = 3; c0 = n_clr; link_ok_i = 0;
    for (int i = 0; i < P + 3; i++) begin if (n_clr != c0) break; @(negedge clk); end
    link_ok_i = 1;
    pulse_det();
    cyc(12);
    chk(prot_state_o == 1, "R11 held detach", prot_state_o, 1);

    summary();
    $finish;
  end
endmodule